// File: doc/BRIEF.md
# Oversampling Serial Receiver with Mute Wake-Up

This block turns an asynchronous serial line into received characters. The line is sampled on a 16x tick, and each frame carries one start bit, 8 or 9 data bits sent least significant bit first, and one stop bit. Each bit is decided by a vote over three samples taken near the bit centre. The block flags noisy bits, a bad stop bit, and a character that arrives before software has read the previous one.

On a shared multidrop line a node can put its receiver into mute. A muted receiver still decodes every frame, but it raises neither the data-ready flag nor the interrupt. Mute ends only on the wake event that the wake-select input picks. With wake-select low that event is an idle line. With wake-select high it is a 9-bit frame whose ninth bit is 1, and that frame is then delivered as normal data. Software decides whether the address belongs to this node and may set mute again at any time.

Top module: `uart_mute_rx`

## Requirements
- R1: After reset, and on every cycle after a cycle with `rx_en` low, `data_ready`, `overrun`, `frame_err`, `noise_err` and `idle_flag` are 0. While `rx_en` is low, a frame on the line is not received.
- R2: With `nine_bit` low, a frame of start bit 0, eight data bits LSB first and stop bit 1 sets `data_ready` and puts the data bits on `rx_data`. `rx_bit8` is 0.
- R3: With `nine_bit` high, a frame with nine data bits puts the first eight on `rx_data` and the ninth on `rx_bit8`.
- R4: `rx_irq` equals `data_ready`. A one-cycle `data_rd` pulse clears `data_ready`.
- R5: Each bit value is the majority of samples 7, 8 and 9 of its 16 ticks. `noise_err` is set when a stored frame had a bit whose three samples disagreed.
- R6: `frame_err` is set when the stop bit of a stored frame is decided as 0.
- R7: When a frame completes while `data_ready` is still 1, `overrun` is set and `rx_data` keeps the earlier character.
- R8: While `mute` is 1, a completed frame that is not the selected wake event leaves `data_ready`, `rx_irq` and `rx_data` unchanged.
- R9: With `wake_sel` high and `nine_bit` high, a frame with ninth bit 1 clears `mute` and is delivered as in R3.
- R10: With `wake_sel` low, `mute` is cleared and `idle_flag` is set once the line has stayed at 1 for one frame time (10 or 11 bit times) after activity.
- R11: The event that `wake_sel` does not select leaves `mute` at 1: an idle line when `wake_sel` is high, and a frame with ninth bit 1 when it is low.
- R12: A `mute_set` pulse sets `mute` at any time, including while a frame is being received, and that frame is then not delivered. A `mute_clr` pulse clears `mute`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_tick | input | 1 | Sample enable at 16x the bit rate |
| rx_in | input | 1 | Serial line, idles at 1 |
| rx_en | input | 1 | Receiver enable. Low holds the receiver and its flags cleared |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_sel | input | 1 | Wake event: 0 is an idle line, 1 is ninth bit set |
| mute_set | input | 1 | Pulse that sets mute |
| mute_clr | input | 1 | Pulse that clears mute |
| data_rd | input | 1 | Pulse that marks the character as read |
| rx_data | output | 8 | Received data bits |
| rx_bit8 | output | 1 | Received ninth bit |
| data_ready | output | 1 | Character waiting to be read |
| rx_irq | output | 1 | Receive interrupt request |
| mute | output | 1 | Mute state |
| idle_flag | output | 1 | Idle line seen (sticky) |
| overrun | output | 1 | Character lost (sticky) |
| frame_err | output | 1 | Stop bit sampled low (sticky) |
| noise_err | output | 1 | Sample disagreement (sticky) |

## Verification
The bench sends a muted frame whose ninth bit is 0, and then one whose ninth bit is 1. A design that wakes on any frame, or that drops the waking frame, fails on one of these. It holds the line idle while waking by ninth bit is selected, and sends an addressed frame while waking by idle is selected, so a receiver that leaves mute on the wrong event is caught. It also checks that idle is not reported after only part of a frame time. A one-sample glitch placed on sample 8 checks both the majority value and the noise flag, and two unread frames check that the first character survives an overrun. It sets mute in the middle of a frame to confirm that frame is dropped, and it runs random 8-bit and 9-bit traffic.

// File: rtl/uart_mute_rx.sv
module uart_mute_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_tick,
  input  logic       rx_in,
  input  logic       rx_en,
  input  logic       nine_bit,
  input  logic       wake_sel,
  input  logic       mute_set,
  input  logic       mute_clr,
  input  logic       data_rd,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       data_ready,
  output logic       rx_irq,
  output logic       mute,
  output logic       idle_flag,
  output logic       overrun,
  output logic       frame_err,
  output logic       noise_err
);
  localparam int OVS = 16;
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2 + 1;
  localparam int IW  = $clog2(11 * OVS + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic [3:0]    bitn;
  logic [8:0]    sh;
  logic          s7, s8, nz, armed;
  logic [IW-1:0] idle_cnt;

  wire          r          = sync[1];
  wire          mid        = rx_en && rx_tick && st != S_IDLE && cnt == CW'(MID);
  wire          maj        = (s7 & s8) | (s7 & r) | (s8 & r);
  wire          noisy      = !((s7 == s8) && (s8 == r));
  wire          done       = mid && st == S_STOP;
  wire [IW-1:0] idle_lim   = nine_bit ? IW'(11 * OVS - 1) : IW'(10 * OVS - 1);
  wire          idle_hit   = rx_en && rx_tick && st == S_IDLE && r && armed && idle_cnt == idle_lim;
  wire [7:0]    f_data     = nine_bit ? sh[7:0] : sh[8:1];
  wire          f_b8       = nine_bit & sh[8];
  wire          wake_frame = done && mute && wake_sel && f_b8;
  wire          deliver    = done && (!mute || wake_frame);
  wire [3:0]    nbits      = nine_bit ? 4'd9 : 4'd8;

  assign rx_irq = data_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; sh <= '0;
      s7 <= 1'b1; s8 <= 1'b1; nz <= 1'b0; armed <= 1'b0; idle_cnt <= '0;
    end else if (!rx_en) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; nz <= 1'b0; armed <= 1'b0; idle_cnt <= '0;
    end else if (rx_tick) begin
      if (st == S_IDLE) begin
        cnt  <= '0;
        bitn <= '0;
        if (!r) begin
          st <= S_START; armed <= 1'b1; idle_cnt <= '0;
        end else if (idle_hit) begin
          armed <= 1'b0; idle_cnt <= '0;
        end else if (armed) begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(MID - 2)) s7 <= r;
        if (cnt == CW'(MID - 1)) s8 <= r;
        if (mid) begin
          case (st)
            S_START: if (maj) st <= S_IDLE; else nz <= noisy;
            S_DATA: begin
              sh   <= {maj, sh[8:1]};
              bitn <= bitn + 1'b1;
              nz   <= nz | noisy;
            end
            S_STOP:  st <= S_IDLE;
            default: ;
          endcase
        end
        if (cnt == CW'(OVS - 1)) begin
          if (st == S_START) st <= S_DATA;
          else if (st == S_DATA && bitn == nbits) st <= S_STOP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_bit8 <= 1'b0; data_ready <= 1'b0; mute <= 1'b0;
      idle_flag <= 1'b0; overrun <= 1'b0; frame_err <= 1'b0; noise_err <= 1'b0;
    end else begin
      if (!rx_en) begin
        data_ready <= 1'b0; overrun <= 1'b0; frame_err <= 1'b0;
        noise_err <= 1'b0; idle_flag <= 1'b0;
      end else begin
        if (data_rd)  data_ready <= 1'b0;
        if (idle_hit) idle_flag  <= 1'b1;
        if (deliver) begin
          if (data_ready && !data_rd) begin
            overrun <= 1'b1;
          end else begin
            rx_data    <= f_data;
            rx_bit8    <= f_b8;
            data_ready <= 1'b1;
            frame_err  <= frame_err | !maj;
            noise_err  <= noise_err | nz | noisy;
          end
        end
      end
      if (wake_frame || (idle_hit && !wake_sel) || mute_clr) mute <= 1'b0;
      else if (mute_set)                                      mute <= 1'b1;
    end
  end
endmodule

module uart_mute_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       wake_sel,
  input logic       mute_clr,
  input logic [7:0] rx_data,
  input logic       rx_bit8,
  input logic       data_ready,
  input logic       mute,
  input logic       idle_flag,
  input logic       overrun,
  input logic       frame_err,
  input logic       noise_err
);
  a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !data_ready && !overrun && !frame_err && !noise_err && !idle_flag);

  a_r8_no_ready_in_mute: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> !($past(mute) && mute));

  a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && $past(data_ready)) |-> $stable(rx_data));

  a_r9_bit_wake_delivers: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mute) && $past(wake_sel) && !$past(mute_clr) && !$past(data_ready))
      |-> data_ready && rx_bit8);

  a_r10_idle_wake_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mute) && !$past(wake_sel) && !$past(mute_clr)) |-> idle_flag);
endmodule

bind uart_mute_rx uart_mute_rx_chk chk_i (.*);

// File: tb/uart_mute_rx_tb.sv
module uart_mute_rx_tb_top;
  logic clk = 0, rst_n = 0, rx_tick = 0, rx_in = 1, rx_en = 0;
  logic nine_bit = 0, wake_sel = 0, mute_set = 0, mute_clr = 0, data_rd = 0;
  logic [7:0] rx_data;
  logic rx_bit8, data_ready, rx_irq, mute, idle_flag, overrun, frame_err, noise_err;
  int total = 0, bad = 0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) rx_tick <= ~rx_tick;

  uart_mute_rx dut_i (.*);

  function automatic logic [7:0] exp_data(input logic [8:0] w);
    return w[7:0];
  endfunction
  function automatic logic exp_b8(input logic [8:0] w, input logic nb);
    return nb & w[8];
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] w, input logic nb, input logic stop_v,
                      input int gl_bit, input logic mm);
    int nframe = nb ? 11 : 10;
    for (int b = 0; b < nframe; b++) begin
      logic v = (b == 0) ? 1'b0 : (b == nframe - 1) ? stop_v : w[b-1];
      for (int c = 0; c < 32; c++) begin
        rx_in    = (b == gl_bit && (c == 17 || c == 18)) ? ~v : v;
        mute_set = mm && b == 5 && c == 0;
        @(negedge clk);
      end
    end
    rx_in = 1;
    mute_set = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_rd();
    data_rd = 1; @(negedge clk); data_rd = 0; @(negedge clk);
  endtask
  task automatic toggle_en();
    rx_en = 0; repeat (3) @(negedge clk); rx_en = 1; @(negedge clk);
  endtask
  task automatic do_mute();
    mute_set = 1; @(negedge clk); mute_set = 0; @(negedge clk);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!data_ready && !overrun && !frame_err && !noise_err && !idle_flag && !mute,
        "R1 reset", {data_ready, overrun, frame_err, noise_err, idle_flag, mute}, 0);

    send(9'h0F0, 0, 1, -1, 0);
    chk(!data_ready, "R1 disabled ignores line", data_ready, 0);
    rx_en = 1; @(negedge clk);

    send(9'h0A5, 0, 1, -1, 0);
    chk(data_ready && rx_data == exp_data(9'h0A5) && rx_bit8 == 0, "R2 8-bit data",
        rx_data, exp_data(9'h0A5));
    chk(rx_irq == 1, "R4 irq with ready", rx_irq, 1);
    pulse_rd();
    chk(!data_ready && !rx_irq, "R4 read clears", {data_ready, rx_irq}, 0);

    nine_bit = 1;
    send(9'h13C, 1, 1, -1, 0);
    chk(rx_data == exp_data(9'h13C) && rx_bit8 == exp_b8(9'h13C, 1), "R3 ninth bit",
        {rx_bit8, rx_data}, 9'h13C);
    pulse_rd();
    nine_bit = 0;

    send(9'h055, 0, 1, 4, 0);
    chk(rx_data == 8'h55, "R5 majority value", rx_data, 8'h55);
    chk(noise_err, "R5 noise flag", noise_err, 1);
    chk(!frame_err, "R6 no framing error on good stop", frame_err, 0);
    pulse_rd();
    toggle_en();
    chk(!noise_err, "R1 disable clears noise", noise_err, 0);

    send(9'h0C3, 0, 0, -1, 0);
    repeat (64) @(negedge clk);
    chk(frame_err, "R6 framing error", frame_err, 1);
    pulse_rd();
    toggle_en();

    send(9'h011, 0, 1, -1, 0);
    send(9'h022, 0, 1, -1, 0);
    chk(overrun && rx_data == 8'h11, "R7 overrun keeps first", {overrun, rx_data}, 9'h111);
    pulse_rd();
    toggle_en();

    nine_bit = 1; wake_sel = 1;
    do_mute();
    send(9'h077, 1, 1, -1, 0);
    chk(!data_ready && !rx_irq && mute, "R8 muted frame dropped", {data_ready, mute}, 1);
    repeat (500) @(negedge clk);
    chk(mute, "R11 idle ignored with bit wake", mute, 1);
    send(9'h142, 1, 1, -1, 0);
    chk(!mute && data_ready && rx_data == 8'h42 && rx_bit8, "R9 address frame wakes",
        {mute, data_ready, rx_bit8, rx_data}, 11'h342);
    pulse_rd();

    toggle_en();
    wake_sel = 0;
    do_mute();
    send(9'h199, 1, 1, -1, 0);
    chk(mute && !data_ready, "R11 address ignored with idle wake", {mute, data_ready}, 2);
    chk(rx_data == 8'h42, "R8 data unchanged in mute", rx_data, 8'h42);
    repeat (120) @(negedge clk);
    chk(mute && !idle_flag, "R10 no early idle", {mute, idle_flag}, 2);
    repeat (400) @(negedge clk);
    chk(!mute && idle_flag, "R10 idle wakes", {mute, idle_flag}, 1);

    toggle_en();
    nine_bit = 0;
    send(9'h0E7, 0, 1, -1, 1);
    chk(mute && !data_ready, "R12 mute set mid-frame", {mute, data_ready}, 2);
    mute_clr = 1; @(negedge clk); mute_clr = 0; @(negedge clk);
    chk(!mute, "R12 mute clear", mute, 0);
    send(9'h0E7, 0, 1, -1, 0);
    chk(data_ready && rx_data == 8'hE7, "R12 receives after clear", rx_data, 8'hE7);
    pulse_rd();

    for (int i = 0; i < 20; i++) begin
      logic [8:0] w = 9'($urandom);
      logic nb = 1'($urandom);
      nine_bit = nb;
      @(negedge clk);
      send(w, nb, 1, -1, 0);
      chk(data_ready && rx_data == exp_data(w) && rx_bit8 == exp_b8(w, nb)
          && !noise_err && !frame_err && !overrun, nb ? "R3 random" : "R2 random",
          {rx_bit8, rx_data}, {exp_b8(w, nb), exp_data(w)});
      pulse_rd();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule